// File: doc/BRIEF.md
# Fractional Clock Rate Controller

The block takes a parent clock and produces a registered clock-enable strobe. Within every window of 32 parent cycles it passes a programmable number of cycles and swallows the rest. The strobe is meant to drive a downstream glitch-free gating cell. The rate is set through a 5-bit frequency-control field. The number of passed cycles per window is 32 minus that field, so a field of 0 gives the full parent rate and a field of 31 gives one cycle in 32.

Software writes the new field into a control register, where it is only staged. It then sets a kick bit in a second register. The kick bit reads back as 1 while the change is pending. The controller swaps the active multiplier at the next window boundary, so no window is ever split between two ratios, and the kick bit then clears by itself. While a change is pending, writes to the field are refused so the value being applied cannot move. Inside a window an accumulator spreads the passed cycles evenly instead of bunching them together.

Top module: `frac_clk_ctrl`

## Requirements
- R1: While reset is high, `clk_en_o` and `busy_o` are 0. After reset the control register reads 0, the kick register reads 0 and the output runs at full rate (32 enables per 32 cycles).
- R2: Once a field value F has been applied, every run of 32 consecutive cycles holds exactly 32 − F enables, for each F from 0 to 31.
- R3: The control register is at address 1. The field occupies bits 12:8, and all other bits of a write are stored and read back unchanged.
- R4: Writing the control register does not change the output rate until a kick is issued.
- R5: The kick register is at address 0, and its kick flag is bit 31. Writing 1 to bit 31 starts a pending change. While the change is pending, bit 31 reads back as 1 and `busy_o` is 1. All other bits of the kick register read as 0.
- R6: The pending flag clears by itself at the next 32-cycle window boundary, no more than 33 cycles after the kick write. The new ratio is in effect from that boundary on.
- R7: While a change is pending, a control-register write leaves bits 12:8 unchanged and updates every other bit.
- R8: Field 0 gives an enable on every cycle. Field 31 gives exactly one enable per 32 cycles.
- R9: When the multiplier is 16 or less, no two enables fall on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data appears on `rdata` one cycle later |
| addr | input | 2 | Register word address (0 = kick, 1 = control) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| clk_en_o | output | 1 | Registered pulse-swallowing clock enable |
| busy_o | output | 1 | High while a staged ratio is waiting to be applied |

## Verification
The bench sweeps every field value from 0 to 31. For each value it first counts enables before the kick and then counts them again after the kick. This separates the staging path from the apply path, and it would expose an inverted or off-by-one multiplier. Control words with non-zero bits outside the field show whether the field is extracted at the right position. A write issued straight after a kick shows whether the field is frozen while the other bits stay writable. At multiplier 16 the bench examines the enable pattern cycle by cycle, which tells an even spread apart from bunched enables that would give the same total count.

// File: rtl/frac_pkg.sv
package frac_pkg;
  localparam int DATA_W_DEF    = 32;
  localparam int ADDR_W_DEF    = 2;
  localparam int FIELD_W_DEF   = 5;
  localparam int FIELD_LSB_DEF = 8;
  localparam int KICK_BIT_DEF  = 31;

  typedef enum logic [1:0] {
    REG_KICK = 2'd0,
    REG_CTRL = 2'd1
  } reg_sel_e;
endpackage

// File: rtl/frac_regs.sv
module frac_regs #(
  parameter int DATA_W    = frac_pkg::DATA_W_DEF,
  parameter int ADDR_W    = frac_pkg::ADDR_W_DEF,
  parameter int FIELD_W   = frac_pkg::FIELD_W_DEF,
  parameter int FIELD_LSB = frac_pkg::FIELD_LSB_DEF,
  parameter int KICK_BIT  = frac_pkg::KICK_BIT_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic               apply_i,
  output logic               pending_o,
  output logic [FIELD_W-1:0] field_o
);
  import frac_pkg::*;

  localparam logic [DATA_W-1:0] FIELD_MASK =
    DATA_W'(((1 << FIELD_W) - 1) << FIELD_LSB);

  logic [DATA_W-1:0] ctrl_q;
  logic              pending_q;
  logic              sel_ctrl, sel_kick;

  assign sel_ctrl = (addr == ADDR_W'(REG_CTRL));
  assign sel_kick = (addr == ADDR_W'(REG_KICK));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en && sel_ctrl) begin
      if (pending_q)
        ctrl_q <= (wdata & ~FIELD_MASK) | (ctrl_q & FIELD_MASK);
      else
        ctrl_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      pending_q <= 1'b0;
    else if (wr_en && sel_kick && wdata[KICK_BIT])
      pending_q <= 1'b1;
    else if (apply_i)
      pending_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (sel_ctrl)
        rdata <= ctrl_q;
      else if (sel_kick)
        rdata <= DATA_W'(pending_q) << KICK_BIT;
      else
        rdata <= '0;
    end
  end

  assign pending_o = pending_q;
  assign field_o   = ctrl_q[FIELD_LSB +: FIELD_W];

  // R7: staged field frozen while a change is pending
  p_field_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    pending_q |=> $stable(field_o));
endmodule

// File: rtl/frac_window.sv
module frac_window #(
  parameter int FIELD_W = frac_pkg::FIELD_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pending_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic               apply_o,
  output logic               win_last_o,
  output logic [FIELD_W:0]   mult_o
);
  localparam int            WINDOW = 1 << FIELD_W;
  localparam logic [FIELD_W:0] WIN_V = (FIELD_W+1)'(WINDOW);

  logic [FIELD_W-1:0] win_cnt;
  logic [FIELD_W:0]   mult_q;
  logic [FIELD_W+1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst) win_cnt <= '0;
    else     win_cnt <= win_cnt + 1'b1;
  end

  assign win_last_o = &win_cnt;
  assign apply_o    = win_last_o & pending_i;

  always_ff @(posedge clk) begin
    if (rst)          mult_q <= WIN_V;
    else if (apply_o) mult_q <= WIN_V - {1'b0, field_i};
  end

  assign mult_o = mult_q;

  always_ff @(posedge clk) begin
    if (rst || !pending_i) wait_cnt <= '0;
    else                   wait_cnt <= wait_cnt + 1'b1;
  end

  // R6: multiplier only changes at a window boundary
  p_switch_boundary_r6: assert property (@(posedge clk) disable iff (rst)
    !win_last_o |=> $stable(mult_o));
  // R6: pending flag only clears at a boundary
  p_kick_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (pending_i && !win_last_o) |=> pending_i);
  // R6: bounded apply latency
  p_kick_latency_r6: assert property (@(posedge clk) disable iff (rst)
    wait_cnt <= (FIELD_W+2)'(WINDOW));
  // R2: multiplier stays within 1..WINDOW
  p_mult_range_r2: assert property (@(posedge clk) disable iff (rst)
    (mult_o >= 1) && (mult_o <= WIN_V));
endmodule

// File: rtl/frac_accum.sv
module frac_accum #(
  parameter int FIELD_W = frac_pkg::FIELD_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FIELD_W:0] mult_i,
  input  logic             win_last_i,
  output logic             en_o
);
  localparam int WINDOW = 1 << FIELD_W;
  localparam logic [FIELD_W+1:0] WIN_S = (FIELD_W+2)'(WINDOW);

  logic [FIELD_W:0]   acc_q;
  logic [FIELD_W+1:0] sum;
  logic               over;
  logic               en_q;

  assign sum  = {1'b0, acc_q} + {1'b0, mult_i};
  assign over = (sum >= WIN_S);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= over;
      if (win_last_i)
        acc_q <= '0;
      else if (over)
        acc_q <= FIELD_W'(sum - WIN_S);
      else
        acc_q <= sum[FIELD_W:0];
    end
  end

  assign en_o = en_q;

  // R8: full multiplier passes every cycle
  p_full_rate_r8: assert property (@(posedge clk) disable iff (rst)
    (mult_i == (FIELD_W+1)'(WINDOW)) |=> en_o);
  // R9: at half rate or below no back-to-back enables
  p_spread_r9: assert property (@(posedge clk) disable iff (rst)
    (en_o && mult_i <= (FIELD_W+1)'(WINDOW/2)) |=> !en_o);
endmodule

// File: rtl/frac_clk_ctrl.sv
module frac_clk_ctrl #(
  parameter int DATA_W    = frac_pkg::DATA_W_DEF,
  parameter int ADDR_W    = frac_pkg::ADDR_W_DEF,
  parameter int FIELD_W   = frac_pkg::FIELD_W_DEF,
  parameter int FIELD_LSB = frac_pkg::FIELD_LSB_DEF,
  parameter int KICK_BIT  = frac_pkg::KICK_BIT_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              clk_en_o,
  output logic              busy_o
);
  logic               apply;
  logic               pending;
  logic               win_last;
  logic [FIELD_W-1:0] field;
  logic [FIELD_W:0]   mult;

  frac_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W),
    .FIELD_LSB(FIELD_LSB), .KICK_BIT(KICK_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .apply_i(apply),
    .pending_o(pending), .field_o(field)
  );

  frac_window #(.FIELD_W(FIELD_W)) u_window (
    .clk(clk), .rst(rst), .pending_i(pending), .field_i(field),
    .apply_o(apply), .win_last_o(win_last), .mult_o(mult)
  );

  frac_accum #(.FIELD_W(FIELD_W)) u_accum (
    .clk(clk), .rst(rst), .mult_i(mult), .win_last_i(win_last),
    .en_o(clk_en_o)
  );

  assign busy_o = pending;

  // R1: outputs quiet while in reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!clk_en_o && !busy_o));
endmodule

// File: tb/test_frac_clk_ctrl.sv
module test_frac_clk_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        clk_en_o;
  logic        busy_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  frac_clk_ctrl i_frac_clk_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .clk_en_o(clk_en_o), .busy_o(busy_o)
  );

  task automatic check(input bit ok, input string req,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic count_en(output int n, output bit b2b);
    bit prev = 1'b0;
    n = 0; b2b = 1'b0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (clk_en_o) n++;
      if (clk_en_o && prev) b2b = 1'b1;
      prev = clk_en_o;
    end
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy_o && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    int n; bit b;
    repeat (3) @(negedge clk);
    check(!clk_en_o && !busy_o, "R1 quiet in reset", {clk_en_o, busy_o}, 0);
    rst = 1'b0;
    bus_read(2'd1, d);
    check(d == 0, "R1 ctrl reset", d, 0);
    bus_read(2'd0, d);
    check(d == 0, "R1 kick reset", d, 0);
    count_en(n, b);
    check(n == 32, "R1 full rate after reset", n, 32);
  endtask

  task automatic t_field_pos;
    logic [31:0] d;
    int n, cyc; bit b;
    bus_write(2'd1, 32'hDEAD_03C5);
    bus_read(2'd1, d);
    check(d == 32'hDEAD_03C5, "R3 readback", d, 32'hDEAD_03C5);
    count_en(n, b);
    check(n == 32, "R4 no change before kick", n, 32);
    bus_write(2'd0, 32'h8000_0000);
    bus_read(2'd0, d);
    check(d == 32'h8000_0000, "R5 kick reads back", d, 32'h8000_0000);
    wait_idle(cyc);
    check(cyc <= 33, "R6 kick self-clears", cyc, 33);
    repeat (40) @(negedge clk);
    count_en(n, b);
    check(n == 29, "R3 field bits 12:8 = 3", n, 29);
  endtask

  task automatic t_sweep;
    logic [31:0] d;
    int n, cyc, prev_m; bit b;
    prev_m = 29;
    for (int f = 0; f < 32; f++) begin
      bus_write(2'd1, {16'h0, 3'b0, 5'(f), 8'h5A});
      count_en(n, b);
      check(n == prev_m, "R4 staged only", n, prev_m);
      bus_write(2'd0, 32'h8000_0000);
      check(busy_o == 1'b1, "R5 busy while pending", busy_o, 1);
      wait_idle(cyc);
      check(cyc <= 33, "R6 apply latency", cyc, 33);
      repeat (40) @(negedge clk);
      count_en(n, b);
      check(n == 32 - f, "R2 enables per window", n, 32 - f);
      if (f == 0)  check(n == 32, "R8 field 0 full rate", n, 32);
      if (f == 31) check(n == 1, "R8 field 31 one per window", n, 1);
      if (f == 16) check(!b, "R9 no back-to-back at mult 16", b, 0);
      if (f == 20) check(!b, "R9 no back-to-back at mult 12", b, 0);
      prev_m = 32 - f;
    end
  endtask

  task automatic t_frozen;
    logic [31:0] d;
    int n, cyc; bit b;
    bus_write(2'd1, 32'h0000_0A00);
    bus_write(2'd0, 32'h8000_0000);
    wait_idle(cyc);
    repeat (40) @(negedge clk);
    count_en(n, b);
    check(n == 22, "R2 field 10", n, 22);
    bus_write(2'd1, 32'h0000_0400);
    bus_write(2'd0, 32'h8000_0000);
    bus_write(2'd1, 32'h1234_1FFF);
    bus_read(2'd1, d);
    check(d == 32'h1234_04FF, "R7 field frozen while pending", d, 32'h1234_04FF);
    wait_idle(cyc);
    repeat (40) @(negedge clk);
    count_en(n, b);
    check(n == 28, "R7 staged value applied", n, 28);
    bus_read(2'd0, d);
    check(d == 0, "R5 kick reads 0 when idle", d, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_field_pos();
    t_sweep();
    t_frozen();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule